// File: doc/BRIEF.md
# Accumulator ALU with Sign, Overflow, Zero and Carry Flags

This block is the arithmetic and logic unit of a small accumulator processor. It is purely combinational. In one evaluation it takes a 4-bit operation code, the register operand, the memory operand, the current carry flag and the current overflow flag. It returns the result byte, the new N, V, Z and C flags, and one write-enable for each flag. The enables tell the surrounding status register which flags the operation owns. A flag whose enable is low is not owned, and its output repeats its input unchanged. Arithmetic is binary only.

The one-operand operations (the four shifts and rotates, increment and decrement) act on the memory operand. The sequencer routes the accumulator onto that port when the accumulator is the target. Compare and bit test change no register, so the block returns the register operand as the result for them.

The processor uses a few flag conventions of its own:
- Subtract and compare treat carry as an inverted borrow, so C=1 means no borrow.
- Compare sets C when register ≥ memory.
- Bit test copies memory bits 7 and 6 straight into N and V.

The datapath is combinational, and data arrives with the instruction that uses it. The edge therefore has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or data pin that is sampled in the cycle the sequencer uses it.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) returns reg + mem + carry modulo 256, with C set when the unsigned sum exceeds 255.
- R2: For add, V is set when the register and memory operands have the same sign bit and the result sign differs. Subtract (code 1) applies the same rule with the memory operand inverted.
- R3: Operation code 1 (subtract) returns reg − mem − (1 − carry) modulo 256. C is 1 when no borrow occurs, that is when reg ≥ mem + (1 − carry).
- R4: Code 5 shifts the memory operand left with 0 into bit 0 and the old bit 7 into C. Code 6 shifts it right with 0 into bit 7 and the old bit 0 into C.
- R5: Code 7 rotates the memory operand left through carry: the old C goes into bit 0 and bit 7 goes into C. Code 8 rotates right through carry: the old C goes into bit 7 and bit 0 goes into C.
- R6: Code 11 (compare) sets C when reg ≥ mem unsigned, Z when they are equal, and N from bit 7 of reg − mem. The result equals reg and V is left unchanged.
- R7: Code 12 (bit test) sets N to mem bit 7, V to mem bit 6, and Z when (reg AND mem) is zero. The result equals reg and C is left unchanged.
- R8: Codes 2, 3 and 4 return reg AND mem, reg OR mem and reg XOR mem. Only N and Z are written.
- R9: Code 9 returns mem + 1 and code 10 returns mem − 1, both wrapping modulo 256. Only N and Z are written.
- R10: For every defined code except bit test, N equals result bit 7 (for compare, bit 7 of the difference) and Z is set when that value is zero.
- R11: wr_n and wr_z are high for all defined codes. wr_c is high for codes 0, 1, 5, 6, 7, 8 and 11. wr_v is high for codes 0, 1 and 12. When an enable is low, v_o equals v_i and c_o equals c_i.
- R12: Undefined codes 13 to 15 return reg, drive all four enables low, and pass V and C through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 add … 12 bit test) |
| reg_i | input | 8 | Register operand |
| mem_i | input | 8 | Memory operand, also the source of one-operand operations |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| res_o | output | 8 | Result byte |
| n_o | output | 1 | New sign flag |
| v_o | output | 1 | New overflow flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| wr_n_o | output | 1 | Sign flag write enable |
| wr_v_o | output | 1 | Overflow flag write enable |
| wr_z_o | output | 1 | Zero flag write enable |
| wr_c_o | output | 1 | Carry flag write enable |

## Verification
The embedded assertions check several properties whenever the inputs settle:
- compare carry against an unsigned magnitude test;
- subtract carry against the borrow rule;
- preservation of the bit count through shifts and rotates;
- the subset property of AND;
- the bit-test copies;
- pass-through of V and C whenever their enables are low.

Exact result values, signed overflow at the ±128 boundaries, wrap of increment and decrement, and the handling of undefined codes are shown only by the bench. Its behavioural model is compared with every output on every clock, over directed corner vectors and a long pseudo-random sweep.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_RTL = 4'd7,
    OP_RTR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] reg_v,
  input  logic [W-1:0] mem_v,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);
  import alu8_pkg::*;
  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic         ci;

  always_comb begin
    x  = reg_v;
    y  = mem_v;
    ci = c_in;
    case (op)
      OP_SUB: begin y = ~mem_v; end
      OP_CMP: begin y = ~mem_v; ci = 1'b1; end
      OP_INC: begin x = mem_v; y = '0; ci = 1'b1; end
      OP_DEC: begin x = mem_v; y = '1; ci = 1'b0; end
      default: ;
    endcase
    {c_out, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    v_out = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

  // compare carry must match an unsigned magnitude test (R6)
  always_comb begin
    if (op == OP_CMP)
      p_cmp_carry_r6: assert (c_out == (reg_v >= mem_v))
        else $error("compare carry disagrees with reg >= mem");
  end

  // subtract carry means no borrow (R3)
  always_comb begin
    if (op == OP_SUB)
      p_sub_noborrow_r3: assert (c_out == (int'(reg_v) >= int'(mem_v) + int'(!c_in)))
        else $error("subtract carry disagrees with borrow rule");
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opd,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_out
);
  import alu8_pkg::*;
  localparam int MSB = W - 1;

  always_comb begin
    res   = opd;
    c_out = c_in;
    case (op)
      OP_SHL: begin res = {opd[MSB-1:0], 1'b0}; c_out = opd[MSB]; end
      OP_SHR: begin res = {1'b0, opd[MSB:1]};   c_out = opd[0];   end
      OP_RTL: begin res = {opd[MSB-1:0], c_in}; c_out = opd[MSB]; end
      OP_RTR: begin res = {c_in, opd[MSB:1]};   c_out = opd[0];   end
      default: ;
    endcase
  end

  // rotates move bits around the carry ring without loss (R5)
  always_comb begin
    if (op == OP_RTL || op == OP_RTR)
      p_rot_keep_r5: assert ($countones({c_out, res}) == $countones({c_in, opd}))
        else $error("rotate lost or created a bit");
  end

  // shifts keep every operand bit in result or carry (R4)
  always_comb begin
    if (op == OP_SHL || op == OP_SHR)
      p_shift_keep_r4: assert ($countones({c_out, res}) == $countones(opd))
        else $error("shift lost or created a bit");
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] reg_v,
  input  logic [W-1:0] mem_v,
  output logic [W-1:0] res
);
  import alu8_pkg::*;

  always_comb begin
    case (op)
      OP_OR:   res = reg_v | mem_v;
      OP_XOR:  res = reg_v ^ mem_v;
      default: res = reg_v & mem_v;
    endcase
  end

  // AND result is a subset of both operands (R8)
  always_comb begin
    if (op == OP_AND)
      p_and_subset_r8: assert (((res & ~reg_v) == '0) && ((res & ~mem_v) == '0))
        else $error("AND result has a bit outside its operands");
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] reg_v,
  input  logic [W-1:0] mem_v,
  input  logic [W-1:0] sum,
  input  logic         add_c,
  input  logic         add_v,
  input  logic [W-1:0] shf_res,
  input  logic         shf_c,
  input  logic [W-1:0] lg_res,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] res,
  output logic         n,
  output logic         v,
  output logic         z,
  output logic         c,
  output logic         wr_n,
  output logic         wr_v,
  output logic         wr_z,
  output logic         wr_c
);
  import alu8_pkg::*;
  localparam int MSB = W - 1;

  logic [W-1:0] fres;

  always_comb begin
    res  = reg_v;
    c    = c_i;
    v    = v_i;
    wr_n = 1'b1;
    wr_z = 1'b1;
    wr_v = 1'b0;
    wr_c = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res = sum; c = add_c; v = add_v; wr_c = 1'b1; wr_v = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: res = lg_res;
      OP_SHL, OP_SHR, OP_RTL, OP_RTR: begin
        res = shf_res; c = shf_c; wr_c = 1'b1;
      end
      OP_INC, OP_DEC: res = sum;
      OP_CMP: begin c = add_c; wr_c = 1'b1; end
      OP_BIT: begin v = mem_v[MSB-1]; wr_v = 1'b1; end
      default: begin wr_n = 1'b0; wr_z = 1'b0; end
    endcase
    fres = res;
    if (op == OP_CMP) fres = sum;
    n = fres[MSB];
    z = (fres == '0);
    if (op == OP_BIT) begin
      n = mem_v[MSB];
      z = (lg_res == '0);
    end
  end

  // unowned overflow flag passes through (R11)
  always_comb begin
    p_v_hold_r11: assert (wr_v || (v == v_i))
      else $error("V changed without its enable");
  end

  // unowned carry flag passes through (R11)
  always_comb begin
    p_c_hold_r11: assert (wr_c || (c == c_i))
      else $error("C changed without its enable");
  end

  // bit test copies memory bits and leaves the register as result (R7)
  always_comb begin
    if (op == OP_BIT)
      p_bit_copy_r7: assert ((n == mem_v[MSB]) && (v == mem_v[MSB-1]) && (res == reg_v))
        else $error("bit test flag copy wrong");
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] mem_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o,
  output logic         wr_n_o,
  output logic         wr_v_o,
  output logic         wr_z_o,
  output logic         wr_c_o
);
  logic [W-1:0] sum, shf_res, lg_res;
  logic         add_c, add_v, shf_c;

  alu8_addsub #(.W(W)) u_add (
    .op(op_i), .reg_v(reg_i), .mem_v(mem_i), .c_in(c_i),
    .sum(sum), .c_out(add_c), .v_out(add_v)
  );

  alu8_shift #(.W(W)) u_shf (
    .op(op_i), .opd(mem_i), .c_in(c_i),
    .res(shf_res), .c_out(shf_c)
  );

  alu8_logic #(.W(W)) u_lg (
    .op(op_i), .reg_v(reg_i), .mem_v(mem_i), .res(lg_res)
  );

  alu8_flags #(.W(W)) u_flg (
    .op(op_i), .reg_v(reg_i), .mem_v(mem_i),
    .sum(sum), .add_c(add_c), .add_v(add_v),
    .shf_res(shf_res), .shf_c(shf_c), .lg_res(lg_res),
    .c_i(c_i), .v_i(v_i),
    .res(res_o), .n(n_o), .v(v_o), .z(z_o), .c(c_o),
    .wr_n(wr_n_o), .wr_v(wr_v_o), .wr_z(wr_z_o), .wr_c(wr_c_o)
  );
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic [7:0] reg_i = '0, mem_i = '0;
  logic       c_i = 1'b0, v_i = 1'b0;
  logic [7:0] res_o;
  logic       n_o, v_o, z_o, c_o, wr_n_o, wr_v_o, wr_z_o, wr_c_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_core dut (
    .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i), .c_i(c_i), .v_i(v_i),
    .res_o(res_o), .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .wr_n_o(wr_n_o), .wr_v_o(wr_v_o), .wr_z_o(wr_z_o), .wr_c_o(wr_c_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (op %0d reg %0h mem %0h c %0d v %0d)",
               tag, what, act, exp, op_i, reg_i, mem_i, c_i, v_i);
    end
  endtask

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R3";
      2, 3, 4: return "R8";
      5, 6: return "R4";
      7, 8: return "R5";
      9, 10: return "R9";
      11: return "R6";
      12: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(int op, int a, int m, int ci, int vi);
    int r, n, z, c, v, wn, wv, wz, wc, s, sr;
    @(posedge clk);
    op_i = op[3:0]; reg_i = a[7:0]; mem_i = m[7:0]; c_i = ci[0]; v_i = vi[0];
    @(negedge clk);
    r = a; c = ci; v = vi; wn = 1; wz = 1; wv = 0; wc = 0;
    case (op)
      0: begin s = a + m + ci; r = s & 255; c = (s > 255) ? 1 : 0;
               sr = sgn(a) + sgn(m) + ci; v = (sr > 127 || sr < -128) ? 1 : 0; wv = 1; wc = 1; end
      1: begin s = a - m - (1 - ci); r = s & 255; c = (s >= 0) ? 1 : 0;
               sr = sgn(a) - sgn(m) - (1 - ci); v = (sr > 127 || sr < -128) ? 1 : 0; wv = 1; wc = 1; end
      2: r = a & m;
      3: r = a | m;
      4: r = a ^ m;
      5: begin r = (m * 2) & 255; c = m / 128; wc = 1; end
      6: begin r = m / 2; c = m % 2; wc = 1; end
      7: begin r = ((m * 2) + ci) & 255; c = m / 128; wc = 1; end
      8: begin r = (m / 2) + ci * 128; c = m % 2; wc = 1; end
      9: r = (m + 1) % 256;
      10: r = (m + 255) % 256;
      11: begin r = a; c = (a >= m) ? 1 : 0; wc = 1; end
      12: begin r = a; v = (m / 64) % 2; wv = 1; end
      default: begin wn = 0; wz = 0; end
    endcase
    if (op == 11) begin n = ((a - m) & 255) / 128; z = (a == m) ? 1 : 0; end
    else if (op == 12) begin n = m / 128; z = ((a & m) == 0) ? 1 : 0; end
    else begin n = r / 128; z = (r == 0) ? 1 : 0; end

    chk(tag_of(op), "result", int'(res_o), r);
    chk((op <= 1) ? "R2" : (op == 12) ? "R7" : "R11", "V flag", int'(v_o), v);
    chk(tag_of(op), "C flag", int'(c_o), c);
    chk((op > 12) ? "R12" : "R11", "enables", int'({wr_n_o, wr_v_o, wr_z_o, wr_c_o}), (wn*8)+(wv*4)+(wz*2)+wc);
    if (wn == 1) begin
      chk((op == 12) ? "R7" : (op == 11) ? "R6" : "R10", "N flag", int'(n_o), n);
      chk((op == 12) ? "R7" : (op == 11) ? "R6" : "R10", "Z flag", int'(z_o), z);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs give add of zero (R10)
    chk("R10", "reset result", int'(res_o), 0);
    chk("R10", "reset Z", int'(z_o), 1);
    rst = 1'b0;

    // R1 / R2 add corners
    apply(0, 8'h50, 8'h50, 0, 0);   // 0xA0, V set
    apply(0, 8'hFF, 8'h01, 0, 1);   // 0, C and Z
    apply(0, 8'h80, 8'h80, 1, 0);   // 0x01, V and C
    apply(0, 8'h7F, 8'h00, 1, 0);   // 0x80, V
    // R3 / R2 subtract corners
    apply(1, 8'h50, 8'hF0, 1, 0);   // 0x60, borrow
    apply(1, 8'h80, 8'h01, 1, 0);   // 0x7F, V
    apply(1, 8'h05, 8'h05, 0, 0);   // borrow in gives FF
    apply(1, 8'h05, 8'h05, 1, 1);   // 0, C=1
    // R8 logic
    apply(2, 8'hF0, 8'h0F, 1, 1);
    apply(3, 8'hA0, 8'h05, 0, 1);
    apply(4, 8'hFF, 8'hFF, 1, 0);
    // R4 / R5 shifts and rotates
    apply(5, 8'h00, 8'h80, 0, 0);
    apply(6, 8'h00, 8'h01, 0, 1);
    apply(7, 8'h00, 8'h80, 1, 0);
    apply(8, 8'h00, 8'h01, 1, 0);
    apply(8, 8'h00, 8'h00, 1, 1);
    // R9 wraps
    apply(9, 8'h12, 8'hFF, 1, 1);
    apply(10, 8'h12, 8'h00, 0, 0);
    apply(9, 8'h12, 8'h7F, 0, 0);
    // R6 compare
    apply(11, 8'h40, 8'h40, 0, 1);
    apply(11, 8'h10, 8'h20, 1, 0);
    apply(11, 8'hF0, 8'h01, 0, 0);
    // R7 bit test
    apply(12, 8'h3F, 8'hC0, 1, 0);
    apply(12, 8'hFF, 8'h01, 0, 1);
    // R12 undefined codes
    apply(13, 8'h9A, 8'h55, 1, 0);
    apply(15, 8'h00, 8'hFF, 0, 1);

    for (int i = 0; i < 3000; i++)
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
            int'($urandom_range(0, 1)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule